// File: doc/BRIEF.md
# Banked Data Memory with Pointer Access

This block is the data-memory side of a small 8-bit processor core. Each request carries a 7-bit file offset. For a direct request the offset is joined to the 5-bit bank number held in the bank register. When the offset names one of the two pointer windows, the access instead goes through a 16-bit pointer that is assembled from two core registers. The decoded request goes to one of five places:

- the core register file, which is the same in every bank;
- a per-bank special-function slot on an outgoing register bus;
- per-bank general-purpose RAM;
- a 16-byte common RAM that every bank shares;
- a read-only program-memory image.

Reads return one cycle after the request, except for reads of the program-memory image, which take one more cycle and raise `stall` while they are pending. Writes return nothing. Instruction decode, the ALU and the peripherals behind the special-function bus are outside this block.

Top module: `dm_banked_mem`

## Requirements
- R1: After a synchronous active-high reset, `rd_valid`, `stall` and `sfr_sel` are low. Every core register, general-purpose byte and common byte then reads 0x00.
- R2: A request is accepted when `acc_en` is high and `stall` is low. An accepted read of a non-program target raises `rd_valid` with `rd_data` in the next cycle. An accepted write never raises `rd_valid`. A direct offset addresses linear location bank*128 + offset, where bank is the bank register.
- R3: Offsets 0x02–0x0B are core registers shared by all banks. Their order is: 0x02 program-counter low, 0x03 status, 0x04/0x05 pointer 0 low/high, 0x06/0x07 pointer 1 low/high, 0x08 bank register, 0x09 working register, 0x0A program-counter latch, 0x0B interrupt control. The bank register keeps only its low 5 bits and reads zero above them.
- R4: Offsets 0x70–0x7F reach the same 16 common bytes from every bank.
- R5: Offsets 0x20–0x6F are 80 general-purpose bytes private to each bank below `GPR_BANKS`. In higher banks they read 0x00 and writes to them are dropped.
- R6: Offsets 0x0C–0x1F drive the special-function bus in the request cycle. `sfr_sel` is high, `sfr_we` follows the request, `sfr_addr` is {bank, offset}, and `sfr_wdata` is the write data. A read returns `sfr_rdata` as sampled in that cycle.
- R7: Offset 0x00 uses pointer 0 and offset 0x01 uses pointer 1. With pointer bit 15 clear, bits 11:0 are the linear data address (bank in bits 11:7). If any of bits 14:12 is set, the access reads 0x00 and writes are dropped.
- R8: An indirect data access whose target offset is 0x00 or 0x01, in any bank, reads 0x00 and its write is discarded.
- R9: With pointer bit 15 set, a read fetches program word bits 14:0 and returns its low 8 bits. `stall` is high for exactly the cycle after the request, and `rd_valid` rises in the cycle after that. Requests presented while `stall` is high are ignored.
- R10: Writes aimed at program memory change nothing and do not raise `stall`.
- R11: Program word i holds (i*157 + `PM_SEED`) mod 2^`PM_W` for i < `PM_DEPTH`. Higher addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Request strobe |
| acc_we | input | 1 | Request is a write |
| file_addr | input | 7 | File offset within the bank |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| rd_valid | output | 1 | Read data valid |
| stall | output | 1 | Program-memory fetch pending |
| sfr_sel | output | 1 | Special-function slot selected |
| sfr_we | output | 1 | Special-function write |
| sfr_addr | output | 12 | {bank, offset} of the special-function slot |
| sfr_wdata | output | 8 | Special-function write data |
| sfr_rdata | input | 8 | Special-function read data |

## Verification
A request is accepted at a clock edge. The special-function bus outputs belong to the request cycle itself, so the bench checks them after driving the inputs and before that edge. For every other read, `rd_valid` and `rd_data` are due one edge after acceptance, and the bench samples them 1 ns after that edge. A program-memory read first shows `stall` high and `rd_valid` low after the first edge, and then its data after the second edge; the bench checks both points. During the stall cycle it also drives a write and later reads the target back, to show that the write was ignored.

// File: rtl/dm_pkg.sv
package dm_pkg;
   localparam int DATA_W    = 8;
   localparam int PTR_W     = 2 * DATA_W;
   // offset map inside one bank (positions decoded by neighbours)
   localparam int OFS_IND0  = 0;
   localparam int OFS_IND1  = 1;
   localparam int OFS_P0LO  = 4;
   localparam int OFS_P0HI  = 5;
   localparam int OFS_P1LO  = 6;
   localparam int OFS_P1HI  = 7;
   localparam int OFS_BANK  = 8;
   localparam int CORE_N    = 12;
   localparam int SFR_LO    = 12;
   localparam int GPR_LO    = 32;
   localparam int GPR_SIZE  = 80;
   localparam int COM_LO    = GPR_LO + GPR_SIZE;
   localparam int COM_SIZE  = 16;
   localparam int PM_FLAG   = PTR_W - 1;

   typedef enum logic [2:0] {
      RG_NONE,
      RG_CORE,
      RG_SFR,
      RG_GPR,
      RG_COM,
      RG_PM
   } region_t;

   function automatic int pm_word(input int idx, input int seed, input int width);
      return (idx * 157 + seed) % (1 << width);
   endfunction
endpackage

// File: rtl/dm_addr_decode.sv
module dm_addr_decode
   import dm_pkg::*;
#(
   parameter int BANK_W    = 5,
   parameter int OFS_W     = 7,
   parameter int GPR_BANKS = 4
) (
   input  logic [OFS_W-1:0]  file_addr,
   input  logic [BANK_W-1:0] bank_reg,
   input  logic [PTR_W-1:0]  ptr0,
   input  logic [PTR_W-1:0]  ptr1,
   output region_t           region,
   output logic [BANK_W-1:0] bank,
   output logic [OFS_W-1:0]  ofs,
   output logic [PM_FLAG-1:0] pm_addr
);
   localparam int LIN_W = BANK_W + OFS_W;

   logic             is_ind;
   logic [PTR_W-1:0] ptr;
   logic             ptr_hole;

   assign is_ind   = (int'(file_addr) == OFS_IND0) || (int'(file_addr) == OFS_IND1);
   assign ptr      = file_addr[0] ? ptr1 : ptr0;
   assign ptr_hole = |ptr[PM_FLAG-1:LIN_W];
   assign pm_addr  = ptr[PM_FLAG-1:0];

   always_comb begin
      region = RG_NONE;
      bank   = bank_reg;
      ofs    = file_addr;
      if (is_ind) begin
         bank = ptr[LIN_W-1:OFS_W];
         ofs  = ptr[OFS_W-1:0];
      end
      if (is_ind && ptr[PM_FLAG]) begin
         region = RG_PM;
      end else if (is_ind && (ptr_hole ||
                   int'(ofs) == OFS_IND0 || int'(ofs) == OFS_IND1)) begin
         region = RG_NONE;
      end else if (int'(ofs) < SFR_LO) begin
         region = RG_CORE;
      end else if (int'(ofs) < GPR_LO) begin
         region = RG_SFR;
      end else if (int'(ofs) < COM_LO) begin
         region = (int'(bank) < GPR_BANKS) ? RG_GPR : RG_NONE;
      end else begin
         region = RG_COM;
      end
   end
endmodule

// File: rtl/dm_core_file.sv
module dm_core_file
   import dm_pkg::*;
#(
   parameter int BANK_W = 5,
   parameter int OFS_W  = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [PTR_W-1:0]  ptr0,
   output logic [PTR_W-1:0]  ptr1,
   output logic [BANK_W-1:0] bank_reg
);
   localparam logic [DATA_W-1:0] BANK_MASK = DATA_W'((1 << BANK_W) - 1);
   localparam int IX_W = $clog2(CORE_N);

   logic [DATA_W-1:0] q [CORE_N];
   logic [IX_W-1:0]   ix;

   assign ix = ofs[IX_W-1:0];

   always_ff @(posedge clk) begin
      for (int i = 0; i < CORE_N; i++) begin
         if (rst || i == OFS_IND0 || i == OFS_IND1) begin
            q[i] <= '0;
         end else if (we && int'(ofs) == i) begin
            q[i] <= (i == OFS_BANK) ? (wdata & BANK_MASK) : wdata;
         end
      end
   end

   assign rdata    = (int'(ofs) < CORE_N) ? q[ix] : '0;
   assign ptr0     = {q[OFS_P0HI], q[OFS_P0LO]};
   assign ptr1     = {q[OFS_P1HI], q[OFS_P1LO]};
   assign bank_reg = q[OFS_BANK][BANK_W-1:0];
endmodule

// File: rtl/dm_ram_banks.sv
module dm_ram_banks
   import dm_pkg::*;
#(
   parameter int BANK_W    = 5,
   parameter int OFS_W     = 7,
   parameter int GPR_BANKS = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we_gpr,
   input  logic              we_com,
   input  logic [BANK_W-1:0] bank,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata_gpr,
   output logic [DATA_W-1:0] rdata_com
);
   localparam int COM_IX_W = $clog2(COM_SIZE);

   logic [DATA_W-1:0]   com_q [COM_SIZE];
   logic [COM_IX_W-1:0] com_ix;

   assign com_ix = ofs[COM_IX_W-1:0];

   always_ff @(posedge clk) begin
      for (int i = 0; i < COM_SIZE; i++) begin
         if (rst) begin
            com_q[i] <= '0;
         end else if (we_com && int'(com_ix) == i) begin
            com_q[i] <= wdata;
         end
      end
   end
   assign rdata_com = com_q[com_ix];

   generate
      if (GPR_BANKS > 0) begin : g_gpr
         localparam int GPR_N = GPR_BANKS * GPR_SIZE;
         localparam int GIX_W = $clog2(GPR_N);

         logic [DATA_W-1:0] gpr_q [GPR_N];
         int                gidx;
         logic              g_ok;
         logic [GIX_W-1:0]  gix;

         assign gidx = int'(bank) * GPR_SIZE + int'(ofs) - GPR_LO;
         assign g_ok = (gidx >= 0) && (gidx < GPR_N);
         assign gix  = g_ok ? gidx[GIX_W-1:0] : '0;

         always_ff @(posedge clk) begin
            for (int i = 0; i < GPR_N; i++) begin
               if (rst) begin
                  gpr_q[i] <= '0;
               end else if (we_gpr && g_ok && gidx == i) begin
                  gpr_q[i] <= wdata;
               end
            end
         end
         assign rdata_gpr = g_ok ? gpr_q[gix] : '0;
      end else begin : g_no_gpr
         assign rdata_gpr = '0;
      end
   endgenerate
endmodule

// File: rtl/dm_prog_rom.sv
module dm_prog_rom
   import dm_pkg::*;
#(
   parameter int PM_DEPTH = 32,
   parameter int PM_W     = 14,
   parameter int PM_SEED  = 'h1A5
) (
   input  logic [PM_FLAG-1:0] addr,
   output logic [DATA_W-1:0]  rbyte
);
   localparam int PIX_W = $clog2(PM_DEPTH);

   // only the byte that reads can return is stored
   logic [DATA_W-1:0] rom [PM_DEPTH];
   logic [PIX_W-1:0]  pix;
   logic              in_range;

   generate
      for (genvar i = 0; i < PM_DEPTH; i++) begin : g_word
         localparam int WORD = pm_word(i, PM_SEED, PM_W);
         assign rom[i] = DATA_W'(WORD);
      end
   endgenerate

   assign in_range = int'(addr) < PM_DEPTH;
   assign pix      = in_range ? addr[PIX_W-1:0] : '0;
   assign rbyte    = in_range ? rom[pix] : '0;
endmodule

// File: rtl/dm_banked_mem.sv
module dm_banked_mem
   import dm_pkg::*;
#(
   parameter int BANK_W    = 5,
   parameter int OFS_W     = 7,
   parameter int GPR_BANKS = 4,
   parameter int PM_DEPTH  = 32,
   parameter int PM_W      = 14,
   parameter int PM_SEED   = 'h1A5
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    acc_en,
   input  logic                    acc_we,
   input  logic [OFS_W-1:0]        file_addr,
   input  logic [DATA_W-1:0]       wdata,
   output logic [DATA_W-1:0]       rd_data,
   output logic                    rd_valid,
   output logic                    stall,
   output logic                    sfr_sel,
   output logic                    sfr_we,
   output logic [BANK_W+OFS_W-1:0] sfr_addr,
   output logic [DATA_W-1:0]       sfr_wdata,
   input  logic [DATA_W-1:0]       sfr_rdata
);
   generate
      if (OFS_W != 7) begin : g_bad_ofs
         $error("OFS_W must be 7 to hold the fixed offset map");
      end
      if (BANK_W < 1 || BANK_W + OFS_W >= PM_FLAG) begin : g_bad_bank
         $error("BANK_W must leave pointer bits above the linear address");
      end
      if (GPR_BANKS < 0 || GPR_BANKS > (1 << BANK_W)) begin : g_bad_gpr
         $error("GPR_BANKS out of range");
      end
      if (PM_DEPTH < 2 || PM_DEPTH > (1 << PM_FLAG)) begin : g_bad_pm
         $error("PM_DEPTH out of range");
      end
      if (PM_W < DATA_W || PM_W > 30) begin : g_bad_pmw
         $error("PM_W out of range");
      end
   endgenerate

   region_t              region;
   logic [BANK_W-1:0]    bank, bank_reg;
   logic [OFS_W-1:0]     ofs;
   logic [PM_FLAG-1:0]   pm_addr, pm_addr_q;
   logic [PTR_W-1:0]     ptr0, ptr1;
   logic [DATA_W-1:0]    core_rd, gpr_rd, com_rd, pm_byte, mux_rd;
   logic                 pm_pend_q, go;

   assign go = acc_en && !pm_pend_q;

   dm_addr_decode #(.BANK_W(BANK_W), .OFS_W(OFS_W), .GPR_BANKS(GPR_BANKS)) u_dec (
      .file_addr(file_addr), .bank_reg(bank_reg), .ptr0(ptr0), .ptr1(ptr1),
      .region(region), .bank(bank), .ofs(ofs), .pm_addr(pm_addr)
   );

   dm_core_file #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_core (
      .clk(clk), .rst(rst),
      .we(go && acc_we && region == RG_CORE),
      .ofs(ofs), .wdata(wdata), .rdata(core_rd),
      .ptr0(ptr0), .ptr1(ptr1), .bank_reg(bank_reg)
   );

   dm_ram_banks #(.BANK_W(BANK_W), .OFS_W(OFS_W), .GPR_BANKS(GPR_BANKS)) u_ram (
      .clk(clk), .rst(rst),
      .we_gpr(go && acc_we && region == RG_GPR),
      .we_com(go && acc_we && region == RG_COM),
      .bank(bank), .ofs(ofs), .wdata(wdata),
      .rdata_gpr(gpr_rd), .rdata_com(com_rd)
   );

   dm_prog_rom #(.PM_DEPTH(PM_DEPTH), .PM_W(PM_W), .PM_SEED(PM_SEED)) u_rom (
      .addr(pm_addr_q), .rbyte(pm_byte)
   );

   assign sfr_sel   = go && region == RG_SFR;
   assign sfr_we    = sfr_sel && acc_we;
   assign sfr_addr  = {bank, ofs};
   assign sfr_wdata = wdata;

   always_comb begin
      unique case (region)
         RG_CORE: mux_rd = core_rd;
         RG_SFR:  mux_rd = sfr_rdata;
         RG_GPR:  mux_rd = gpr_rd;
         RG_COM:  mux_rd = com_rd;
         default: mux_rd = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_data   <= '0;
         rd_valid  <= 1'b0;
         pm_pend_q <= 1'b0;
         pm_addr_q <= '0;
      end else begin
         rd_valid <= 1'b0;
         if (pm_pend_q) begin
            rd_data   <= pm_byte;
            rd_valid  <= 1'b1;
            pm_pend_q <= 1'b0;
         end else if (go && !acc_we) begin
            if (region == RG_PM) begin
               pm_pend_q <= 1'b1;
               pm_addr_q <= pm_addr;
            end else begin
               rd_data  <= mux_rd;
               rd_valid <= 1'b1;
            end
         end
      end
   end

   assign stall = pm_pend_q;
endmodule

// File: rtl/dm_banked_mem_chk.sv
module dm_banked_mem_chk #(
   parameter int OFS_W = 7,
   parameter int ADR_W = 12
) (
   input logic             clk,
   input logic             rst,
   input logic             acc_en,
   input logic             acc_we,
   input logic             rd_valid,
   input logic             stall,
   input logic             sfr_sel,
   input logic             sfr_we,
   input logic [ADR_W-1:0] sfr_addr
);
   p_read_returns_r2: assert property (@(posedge clk) disable iff (rst)
      (acc_en && !acc_we && !stall) |=> (rd_valid || stall));
   p_write_quiet_r2: assert property (@(posedge clk) disable iff (rst)
      (acc_en && acc_we && !stall) |=> (!rd_valid && !stall));
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
      (!acc_en && !stall) |=> (!rd_valid && !stall));
   p_stall_once_r9: assert property (@(posedge clk) disable iff (rst)
      stall |=> !stall);
   p_stall_then_data_r9: assert property (@(posedge clk) disable iff (rst)
      stall |=> rd_valid);
   p_stall_blank_r9: assert property (@(posedge clk) disable iff (rst)
      stall |-> (!rd_valid && !sfr_sel));
   p_sfr_window_r6: assert property (@(posedge clk) disable iff (rst)
      sfr_sel |-> (sfr_addr[OFS_W-1:0] >= 7'h0C && sfr_addr[OFS_W-1:0] <= 7'h1F));
   p_sfr_write_r6: assert property (@(posedge clk) disable iff (rst)
      sfr_we |-> (sfr_sel && acc_en && acc_we));
endmodule

bind dm_banked_mem dm_banked_mem_chk #(.OFS_W(OFS_W), .ADR_W(BANK_W + OFS_W)) u_chk (
   .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
   .rd_valid(rd_valid), .stall(stall), .sfr_sel(sfr_sel),
   .sfr_we(sfr_we), .sfr_addr(sfr_addr)
);

// File: tb/tb_dm_banked_mem.sv
`timescale 1ns/1ps
module tb_dm_banked_mem;
   localparam int PM_DEPTH = 32;
   localparam int PM_W     = 14;
   localparam int PM_SEED  = 'h1A5;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        acc_en = 1'b0, acc_we = 1'b0;
   logic [6:0]  file_addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rd_data;
   logic        rd_valid, stall, sfr_sel, sfr_we;
   logic [11:0] sfr_addr;
   logic [7:0]  sfr_wdata, sfr_rdata;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   // special-function responder: data is a fixed function of the slot address
   assign sfr_rdata = sfr_addr[7:0] ^ 8'h5A;

   dm_banked_mem #(.PM_DEPTH(PM_DEPTH), .PM_W(PM_W), .PM_SEED(PM_SEED)) dut (
      .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
      .file_addr(file_addr), .wdata(wdata), .rd_data(rd_data),
      .rd_valid(rd_valid), .stall(stall), .sfr_sel(sfr_sel), .sfr_we(sfr_we),
      .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
   );

   function automatic logic [7:0] pm_exp(input int i);
      if (i >= PM_DEPTH) return 8'h00;
      return 8'(((i * 157) + PM_SEED) % (1 << PM_W));
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one accepted request; returns 1 ns after the accepting edge
   task automatic acc(input logic we, input logic [6:0] a, input logic [7:0] d);
      acc_en = 1'b1; acc_we = we; file_addr = a; wdata = d;
      @(posedge clk); #1;
      acc_en = 1'b0; acc_we = 1'b0;
   endtask

   task automatic rd_chk(input logic [6:0] a, input logic [7:0] exp, input string req);
      acc(1'b0, a, 8'h00);
      chk(rd_valid && rd_data == exp, req, {rd_valid, rd_data}, {1'b1, exp});
   endtask

   task automatic pm_chk(input logic [6:0] a, input logic [7:0] exp, input string req);
      acc(1'b0, a, 8'h00);
      chk(stall && !rd_valid, req, {stall, rd_valid}, 2'b10);
      @(posedge clk); #1;
      chk(rd_valid && !stall && rd_data == exp, req, {stall, rd_valid, rd_data}, {2'b01, exp});
   endtask

   // {we, addr, wdata, expected read}
   localparam int NV = 21;
   localparam logic [23:0] VEC [NV] = '{
      {1'b1, 7'h09, 8'h3C, 8'h00},   // R3 working register
      {1'b0, 7'h09, 8'h00, 8'h3C},   // R3
      {1'b1, 7'h20, 8'h11, 8'h00},   // R5 bank 0
      {1'b0, 7'h20, 8'h00, 8'h11},   // R5
      {1'b1, 7'h70, 8'h77, 8'h00},   // R4 common
      {1'b1, 7'h08, 8'hFF, 8'h00},   // R3 bank 31
      {1'b0, 7'h08, 8'h00, 8'h1F},   // R3 bank register width
      {1'b0, 7'h09, 8'h00, 8'h3C},   // R3 mirrored
      {1'b0, 7'h70, 8'h00, 8'h77},   // R4 common from bank 31
      {1'b1, 7'h20, 8'h99, 8'h00},   // R5 dropped write
      {1'b0, 7'h20, 8'h00, 8'h00},   // R5 reads zero
      {1'b1, 7'h08, 8'h01, 8'h00},   // R2 bank 1
      {1'b0, 7'h20, 8'h00, 8'h00},   // R5 private to bank
      {1'b1, 7'h21, 8'h42, 8'h00},   // R2
      {1'b0, 7'h21, 8'h00, 8'h42},   // R2
      {1'b1, 7'h70, 8'h55, 8'h00},   // R4
      {1'b1, 7'h08, 8'h00, 8'h00},   // R2 bank 0
      {1'b0, 7'h70, 8'h00, 8'h55},   // R4
      {1'b0, 7'h20, 8'h00, 8'h11},   // R2
      {1'b0, 7'h21, 8'h00, 8'h00},   // R2 distinct linear address
      {1'b0, 7'h6F, 8'h00, 8'h00}    // R5 top of range
   };

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      // R1 reset state
      chk(!rd_valid && !stall && !sfr_sel, "R1", {rd_valid, stall, sfr_sel}, 0);
      rd_chk(7'h09, 8'h00, "R1");
      rd_chk(7'h70, 8'h00, "R1");

      for (int i = 0; i < NV; i++) begin
         acc(VEC[i][23], VEC[i][22:16], VEC[i][15:8]);
         if (VEC[i][23])
            chk(!rd_valid, "R2 write", rd_valid, 0);
         else
            chk(rd_valid && rd_data == VEC[i][7:0], "R2 table read",
                {rd_valid, rd_data}, {1'b1, VEC[i][7:0]});
      end

      // R6 special-function bus, bank 3
      acc(1'b1, 7'h08, 8'h03);
      acc_en = 1'b1; acc_we = 1'b0; file_addr = 7'h15; #1;
      chk(sfr_sel && !sfr_we && sfr_addr == 12'h195, "R6",
          {sfr_sel, sfr_we, sfr_addr}, {2'b10, 12'h195});
      @(posedge clk); #1; acc_en = 1'b0;
      chk(rd_valid && rd_data == (8'h95 ^ 8'h5A), "R6", rd_data, 8'h95 ^ 8'h5A);
      acc_en = 1'b1; acc_we = 1'b1; file_addr = 7'h0C; wdata = 8'hAB; #1;
      chk(sfr_sel && sfr_we && sfr_wdata == 8'hAB && sfr_addr == 12'h18C, "R6",
          {sfr_we, sfr_wdata}, {1'b1, 8'hAB});
      @(posedge clk); #1; acc_en = 1'b0; acc_we = 1'b0;

      // R7 pointer access to bank 1 offset 0x20
      acc(1'b1, 7'h04, 8'hA0);
      acc(1'b1, 7'h05, 8'h00);
      rd_chk(7'h00, 8'h00, "R7");
      acc(1'b1, 7'h00, 8'h5C);
      acc(1'b1, 7'h08, 8'h01);
      rd_chk(7'h20, 8'h5C, "R7");
      acc(1'b1, 7'h08, 8'h00);
      acc(1'b1, 7'h06, 8'h70);
      acc(1'b1, 7'h07, 8'h00);
      rd_chk(7'h01, 8'h55, "R7");
      acc(1'b1, 7'h07, 8'h10);
      rd_chk(7'h01, 8'h00, "R7 hole");
      acc(1'b1, 7'h04, 8'h09);
      rd_chk(7'h00, 8'h3C, "R7 core via pointer");

      // R8 pointer aimed at a pointer window
      acc(1'b1, 7'h04, 8'h81);
      rd_chk(7'h00, 8'h00, "R8");
      acc(1'b1, 7'h00, 8'h33);
      rd_chk(7'h06, 8'h70, "R8");
      rd_chk(7'h07, 8'h10, "R8");

      // R9 / R11 program memory through pointer 1
      acc(1'b1, 7'h06, 8'h05);
      acc(1'b1, 7'h07, 8'h80);
      acc(1'b0, 7'h01, 8'h00);
      chk(stall && !rd_valid, "R9", {stall, rd_valid}, 2'b10);
      acc(1'b1, 7'h09, 8'h00);   // presented during stall, must be ignored
      chk(rd_valid && !stall && rd_data == pm_exp(5), "R9",
          {stall, rd_valid, rd_data}, {2'b01, pm_exp(5)});
      rd_chk(7'h09, 8'h3C, "R9 ignored");
      // R10 write to program memory
      acc(1'b1, 7'h01, 8'hEE);
      chk(!stall && !rd_valid, "R10", {stall, rd_valid}, 0);
      pm_chk(7'h01, pm_exp(5), "R10");
      acc(1'b1, 7'h06, 8'(PM_DEPTH - 1));
      pm_chk(7'h01, pm_exp(PM_DEPTH - 1), "R11");
      acc(1'b1, 7'h06, 8'(PM_DEPTH));
      pm_chk(7'h01, 8'h00, "R11 beyond depth");

      // R1 reset mid-run
      rst = 1'b1;
      repeat (2) @(posedge clk);
      #1 rst = 1'b0;
      chk(!rd_valid && !stall, "R1", {rd_valid, stall}, 0);
      rd_chk(7'h09, 8'h00, "R1");
      rd_chk(7'h70, 8'h00, "R1");
      rd_chk(7'h08, 8'h00, "R1");
      rd_chk(7'h20, 8'h00, "R1");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule